// File: doc/BRIEF.md
# Nesting Interrupt Controller with Status Stack

This block collects active-low external request lines and internal request pulses. It keeps a pending set and picks the highest-priority request that may be served now. It offers that request's vector address to the program sequencer over a valid/ready handshake. Each external line can be set to edge or level sensitivity. Software can set or drop any pending request through a write-only force/clear strobe.

When the sequencer accepts a vector, the block saves the arithmetic status, mode status and interrupt mask words together as one entry on a seven-entry hardware stack. A return-from-interrupt strobe takes that entry back off the stack and restores all three words. One mode pin chooses between nested servicing, where a higher-priority request may preempt a running service, and sequential servicing, where only one service runs at a time.

Handshake rules: `irq_valid` is a live request, not a held data beat. While `irq_ready` is low, the offered vector can change or be withdrawn: a higher-priority request may arrive, a level line may be released, or a request may be cleared. A transfer happens only on a clock edge where both are high. That transfer counts as acceptance.

Top module: `intc_nest`

## Requirements
- R1: An external line set to edge sensitivity (`sense_edge` bit = 1) becomes pending after a high-to-low transition, seen through a two-flop synchroniser. It yields exactly one acceptance per transition, even if the line stays low afterwards.
- R2: A line set to level sensitivity (`sense_edge` bit = 0) is pending only while it is held low. It is never latched, so a low pulse that ends before acceptance leaves no request behind.
- R3: Priority is fixed, and index 0 is the highest. External line k is index k. Internal source j is index N_EXT+j. The vector for index i is VEC_BASE + 4*i, where VEC_BASE defaults to 0x040.
- R4: A request is offered only when its bit in the mask word is 1 and `glob_en` is 1.
- R5: A force/clear write with a force bit set makes that index pending. A clear bit removes it. When both bits are set for the same index, clear wins.
- R6: With `nest_mode` = 1, a pending request is offered only when no service is active or when it outranks every active service.
- R7: With `nest_mode` = 0, no request is offered while any service is active.
- R8: Acceptance pushes {arith, mode, mask} as one stack entry, and the depth rises by one. Each `rti` pulse restores the three words from the newest entry, in last-in first-out order, and the depth falls by one.
- R9: An `rti` pulse with an empty stack sets the sticky `stk_unf` flag and leaves all three status words unchanged.
- R10: An acceptance with seven entries on the stack sets the sticky `stk_ovf` flag. The push is dropped and the depth stays at 7.
- R11: `irq_valid` is low in any cycle where `rti` is high. Each `rti` pulse ends the highest-priority active service.
- R12: A status write with `st_wr_sel` 0 (arith), 1 (mode) or 2 (mask, low bits) loads that word. A restore in the same cycle takes precedence over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_irq_n | input | N_EXT (3) | External request lines, active low |
| int_req | input | N_INT (5) | Internal request pulses, one cycle each |
| sense_edge | input | N_EXT (3) | Per-line sensitivity: 1 edge, 0 level |
| nest_mode | input | 1 | 1 nested servicing, 0 sequential |
| glob_en | input | 1 | Global interrupt enable |
| fc_wr | input | 1 | Force/clear write strobe |
| fc_force | input | NIRQ (8) | Force bits, one per index |
| fc_clear | input | NIRQ (8) | Clear bits, one per index |
| st_wr_en | input | 1 | Status word write strobe |
| st_wr_sel | input | 2 | Status word select |
| st_wr_data | input | SW (16) | Status write data |
| rti | input | 1 | Return-from-interrupt strobe |
| irq_valid | output | 1 | A vector is offered |
| irq_ready | input | 1 | Sequencer takes the vector |
| irq_vector | output | AW (14) | Vector address of the offered request |
| astat | output | SW (16) | Arithmetic status word |
| mstat | output | SW (16) | Mode status word |
| imask | output | NIRQ (8) | Interrupt mask word |
| stk_depth | output | 3 | Entries on the status stack |
| stk_ovf | output | 1 | Sticky stack overflow |
| stk_unf | output | 1 | Sticky stack underflow |

## Verification
The main function is tested with several input patterns. A falling edge held low for a long time tells one-shot edge latching apart from level tracking. A level line released before service shows that nothing is latched. Two forced requests written together show whether the fixed order and the vector arithmetic are right. A descending chain of forced requests from index 7 to index 0 drives nesting to eight levels, which checks the stack boundary, the overflow flag, and the last-in first-out restore of distinct status words. Requests raised while a service runs, once in each mode, separate the preemption rule from the sequential rule, and a strobe issued with an empty stack shows the underflow behaviour.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    SEL_ARITH = 2'd0,
    SEL_MODE  = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_NONE  = 2'd3
  } st_sel_e;

endpackage

// File: rtl/intc_req.sv
module intc_req #(
  parameter int N_EXT = 3,
  parameter int N_INT = 5,
  localparam int NIRQ = N_EXT + N_INT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EXT-1:0] ext_n,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_EXT-1:0] edge_sel,
  input  logic            fc_wr,
  input  logic [NIRQ-1:0] fc_force,
  input  logic [NIRQ-1:0] fc_clear,
  input  logic [NIRQ-1:0] take,
  output logic [NIRQ-1:0] pend
);

  logic [NIRQ-1:0] lat_q;
  logic [NIRQ-1:0] set_ev;
  logic [NIRQ-1:0] clr_ev;

  assign clr_ev = fc_clear & {NIRQ{fc_wr}};

  for (genvar e = 0; e < N_EXT; e++) begin : g_ext
    logic s1_q, s2_q, prev_q;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= ext_n[e];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end

    assign fall      = prev_q & ~s2_q;
    assign set_ev[e] = (edge_sel[e] & fall) | (fc_wr & fc_force[e]);
    assign pend[e]   = lat_q[e] | (~edge_sel[e] & ~s2_q);
  end

  for (genvar j = 0; j < N_INT; j++) begin : g_int
    assign set_ev[N_EXT+j] = int_req[j] | (fc_wr & fc_force[N_EXT+j]);
    assign pend[N_EXT+j]   = lat_q[N_EXT+j];
  end

  for (genvar b = 0; b < NIRQ; b++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat_q[b] <= 1'b0;
      else if (clr_ev[b])  lat_q[b] <= 1'b0;
      else if (set_ev[b])  lat_q[b] <= 1'b1;
      else if (take[b])    lat_q[b] <= 1'b0;
    end

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (fc_wr && fc_clear[b]) |=> !lat_q[b]); // R5
  end

endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int NIRQ = 8,
  parameter int AW   = 14,
  parameter logic [AW-1:0] VEC_BASE = 'h040,
  localparam int IW = (NIRQ > 1) ? $clog2(NIRQ) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NIRQ-1:0] pend,
  input  logic [NIRQ-1:0] mask,
  input  logic            glob_en,
  input  logic            nest,
  input  logic            rti,
  input  logic            ready,
  output logic            valid,
  output logic [AW-1:0]   vector,
  output logic            accept,
  output logic [NIRQ-1:0] take
);

  logic [NIRQ-1:0] isr_q;
  logic [NIRQ-1:0] cand, gnt, cur_oh;
  logic            idle, allowed;
  logic [IW-1:0]   idx;

  assign cand   = pend & mask & {NIRQ{glob_en}};
  assign gnt    = cand & (~cand + 1'b1);
  assign cur_oh = isr_q & (~isr_q + 1'b1);
  assign idle   = (isr_q == '0);

  always_comb begin
    if (nest) allowed = idle || (gnt < cur_oh);
    else      allowed = idle;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NIRQ; i++) begin
      if (gnt[i]) idx = IW'(i);
    end
  end

  assign valid  = (|gnt) & allowed & ~rti;
  assign vector = VEC_BASE + (AW'(idx) << 2);
  assign accept = valid & ready;
  assign take   = accept ? gnt : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= '0;
    else if (rti)    isr_q <= isr_q & ~cur_oh;
    else if (accept) isr_q <= isr_q | gnt;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take)); // R3
  AST_SEQ_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !nest) |-> (isr_q == '0)); // R7
  AST_NEST_RANK: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && isr_q != '0) |-> (take < cur_oh)); // R6
  AST_RTI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rti |-> !accept); // R11
  AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (glob_en && ((take & mask) != '0))); // R4

endmodule

// File: rtl/intc_stack.sv
module intc_stack #(
  parameter int DW    = 40,
  parameter int DEPTH = 7,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] top,
  output logic [PW-1:0] depth,
  output logic          ovf,
  output logic          unf
);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] sp_q;
  logic          full, empty;

  assign full  = (sp_q == PW'(DEPTH));
  assign empty = (sp_q == '0);
  assign depth = sp_q;
  assign top   = empty ? '0 : mem[sp_q - 1'b1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else if (pop) begin
      if (empty) unf  <= 1'b1;
      else       sp_q <= sp_q - 1'b1;
    end else if (push) begin
      if (full)  ovf  <= 1'b1;
      else       sp_q <= sp_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !pop && !full) mem[sp_q] <= din;
  end

  AST_DEPTH_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= PW'(DEPTH)); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R10
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf); // R9
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop)); // R11

endmodule

// File: rtl/intc_nest.sv
module intc_nest #(
  parameter int N_EXT = 3,
  parameter int N_INT = 5,
  parameter int SW    = 16,
  parameter int AW    = 14,
  parameter int DEPTH = 7,
  parameter logic [AW-1:0] VEC_BASE = 'h040,
  localparam int NIRQ = N_EXT + N_INT,
  localparam int DW   = 2 * SW + NIRQ,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] ext_irq_n,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_EXT-1:0] sense_edge,
  input  logic             nest_mode,
  input  logic             glob_en,
  input  logic             fc_wr,
  input  logic [NIRQ-1:0]  fc_force,
  input  logic [NIRQ-1:0]  fc_clear,
  input  logic             st_wr_en,
  input  logic [1:0]       st_wr_sel,
  input  logic [SW-1:0]    st_wr_data,
  input  logic             rti,
  output logic             irq_valid,
  input  logic             irq_ready,
  output logic [AW-1:0]    irq_vector,
  output logic [SW-1:0]    astat,
  output logic [SW-1:0]    mstat,
  output logic [NIRQ-1:0]  imask,
  output logic [PW-1:0]    stk_depth,
  output logic             stk_ovf,
  output logic             stk_unf
);
  import intc_pkg::*;

  logic [NIRQ-1:0] pend, take;
  logic            accept;
  logic [SW-1:0]   astat_q, mstat_q;
  logic [NIRQ-1:0] imask_q;
  logic [DW-1:0]   stk_top;
  logic            restore;
  st_sel_e         sel;

  intc_req #(.N_EXT(N_EXT), .N_INT(N_INT)) u_req (
    .clk(clk), .rst_n(rst_n), .ext_n(ext_irq_n), .int_req(int_req),
    .edge_sel(sense_edge), .fc_wr(fc_wr), .fc_force(fc_force),
    .fc_clear(fc_clear), .take(take), .pend(pend)
  );

  intc_arb #(.NIRQ(NIRQ), .AW(AW), .VEC_BASE(VEC_BASE)) u_arb (
    .clk(clk), .rst_n(rst_n), .pend(pend), .mask(imask_q),
    .glob_en(glob_en), .nest(nest_mode), .rti(rti), .ready(irq_ready),
    .valid(irq_valid), .vector(irq_vector), .accept(accept), .take(take)
  );

  intc_stack #(.DW(DW), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .push(accept), .pop(rti),
    .din({astat_q, mstat_q, imask_q}), .top(stk_top),
    .depth(stk_depth), .ovf(stk_ovf), .unf(stk_unf)
  );

  assign restore = rti && (stk_depth != '0);
  assign sel     = st_sel_e'(st_wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      astat_q <= '0;
      mstat_q <= '0;
      imask_q <= '0;
    end else if (restore) begin
      {astat_q, mstat_q, imask_q} <= stk_top;
    end else if (st_wr_en) begin
      case (sel)
        SEL_ARITH: astat_q <= st_wr_data;
        SEL_MODE:  mstat_q <= st_wr_data;
        SEL_MASK:  imask_q <= st_wr_data[NIRQ-1:0];
        default:   ;
      endcase
    end
  end

  assign astat = astat_q;
  assign mstat = mstat_q;
  assign imask = imask_q;

  AST_POP_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> ({astat_q, mstat_q, imask_q} == $past(stk_top))); // R8
  AST_PUSH_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stk_depth < PW'(DEPTH)) |=> (stk_depth == $past(stk_depth) + 1'b1)); // R8
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && stk_depth == '0 && !st_wr_en) |=>
      ($stable(astat_q) && $stable(mstat_q) && $stable(imask_q) && stk_unf)); // R9
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && stk_depth == PW'(DEPTH)) |=> (stk_ovf && stk_depth == PW'(DEPTH))); // R10

endmodule

// File: tb/intc_nest_test.sv
`timescale 1ns/1ps
module intc_nest_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_irq_n = 3'b111;
  logic [4:0]  int_req = '0;
  logic [2:0]  sense_edge = 3'b001;
  logic        nest_mode = 1'b1;
  logic        glob_en = 1'b0;
  logic        fc_wr = 1'b0;
  logic [7:0]  fc_force = '0;
  logic [7:0]  fc_clear = '0;
  logic        st_wr_en = 1'b0;
  logic [1:0]  st_wr_sel = '0;
  logic [15:0] st_wr_data = '0;
  logic        rti = 1'b0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [13:0] irq_vector;
  logic [15:0] astat, mstat;
  logic [7:0]  imask;
  logic [2:0]  stk_depth;
  logic        stk_ovf, stk_unf;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  intc_nest uut (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .int_req(int_req),
    .sense_edge(sense_edge), .nest_mode(nest_mode), .glob_en(glob_en),
    .fc_wr(fc_wr), .fc_force(fc_force), .fc_clear(fc_clear),
    .st_wr_en(st_wr_en), .st_wr_sel(st_wr_sel), .st_wr_data(st_wr_data),
    .rti(rti), .irq_valid(irq_valid), .irq_ready(irq_ready),
    .irq_vector(irq_vector), .astat(astat), .mstat(mstat), .imask(imask),
    .stk_depth(stk_depth), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  function automatic logic [13:0] vec_of(input int i);
    return 14'h040 + 14'(4 * i);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: scoreboard compare on every handshake
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (irq_valid && irq_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3", "unexpected vector", irq_vector, 0);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(irq_vector == vec_of(e), "R3", "accepted vector", irq_vector, vec_of(e));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "R11", "watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic expect_irq(input int i);
    exp_q.push_back(i);
    @(negedge clk) irq_ready = 1'b1;
    #1;
    while (!irq_valid) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk) irq_ready = 1'b0;
  endtask

  task automatic force_irq(input logic [7:0] f, input logic [7:0] c);
    @(negedge clk);
    fc_wr = 1'b1; fc_force = f; fc_clear = c;
    @(negedge clk);
    fc_wr = 1'b0; fc_force = '0; fc_clear = '0;
  endtask

  task automatic do_rti();
    @(negedge clk) rti = 1'b1;
    @(negedge clk) rti = 1'b0;
  endtask

  task automatic wr_st(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    st_wr_en = 1'b1; st_wr_sel = s; st_wr_data = d;
    @(negedge clk);
    st_wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    idle(3);
    check(irq_valid == 1'b0, "R4", "reset valid", irq_valid, 0);
    check(stk_depth == 0 && !stk_ovf && !stk_unf, "R8", "reset stack", stk_depth, 0);
    @(negedge clk) rst_n = 1'b1;

    wr_st(2'd2, 16'h00FF);
    wr_st(2'd0, 16'hA5A5);
    idle(1);
    check(astat == 16'hA5A5 && imask == 8'hFF, "R12", "status write", astat, 16'hA5A5);
    @(negedge clk) glob_en = 1'b1;

    // R1: edge line 0, held low well past one service
    @(negedge clk) ext_irq_n[0] = 1'b0;
    expect_irq(0);
    do_rti();
    idle(5);
    check(irq_valid == 1'b0, "R1", "one request per edge", irq_valid, 0);
    @(negedge clk) ext_irq_n[0] = 1'b1;

    // R2: level line 1
    @(negedge clk) ext_irq_n[1] = 1'b0;
    expect_irq(1);
    do_rti();
    #1;
    check(irq_valid && irq_vector == vec_of(1), "R2", "level still low", irq_vector, vec_of(1));
    @(negedge clk) ext_irq_n[1] = 1'b1;
    idle(4);
    check(irq_valid == 1'b0, "R2", "level released", irq_valid, 0);
    @(negedge clk) ext_irq_n[2] = 1'b0;
    idle(4);
    @(negedge clk) ext_irq_n[2] = 1'b1;
    idle(4);
    check(irq_valid == 1'b0, "R2", "short level pulse", irq_valid, 0);

    // R3 / R6: two forced requests together
    force_irq(8'h18, 8'h00);
    expect_irq(3);
    idle(2);
    check(irq_valid == 1'b0, "R6", "lower waits", irq_valid, 0);
    do_rti();
    expect_irq(4);
    do_rti();

    // R4: mask and global enable
    wr_st(2'd2, 16'h00EF);
    force_irq(8'h10, 8'h00);
    idle(2);
    check(irq_valid == 1'b0, "R4", "masked bit", irq_valid, 0);
    @(negedge clk) glob_en = 1'b0;
    wr_st(2'd2, 16'h00FF);
    idle(2);
    check(irq_valid == 1'b0, "R4", "global off", irq_valid, 0);
    @(negedge clk) glob_en = 1'b1;
    expect_irq(4);
    do_rti();

    // R5: clear
    force_irq(8'h08, 8'h00);
    force_irq(8'h00, 8'h08);
    idle(2);
    check(irq_valid == 1'b0, "R5", "cleared", irq_valid, 0);
    force_irq(8'h08, 8'h08);
    idle(2);
    check(irq_valid == 1'b0, "R5", "clear wins", irq_valid, 0);

    // R6: nested preemption
    force_irq(8'h10, 8'h00);
    expect_irq(4);
    force_irq(8'h02, 8'h00);
    expect_irq(1);
    idle(1);
    check(stk_depth == 3'd2, "R6", "nested depth", stk_depth, 2);
    force_irq(8'h08, 8'h00);
    idle(2);
    check(irq_valid == 1'b0, "R6", "below active", irq_valid, 0);
    do_rti();
    expect_irq(3);
    do_rti();
    do_rti();
    idle(1);
    check(stk_depth == 3'd0, "R8", "depth back to 0", stk_depth, 0);

    // R7: sequential
    @(negedge clk) nest_mode = 1'b0;
    force_irq(8'h10, 8'h00);
    expect_irq(4);
    force_irq(8'h01, 8'h00);
    idle(2);
    check(irq_valid == 1'b0, "R7", "no preempt", irq_valid, 0);
    do_rti();
    expect_irq(0);
    do_rti();
    @(negedge clk) nest_mode = 1'b1;

    // R8: stack contents
    wr_st(2'd0, 16'h1111);
    wr_st(2'd1, 16'h2222);
    force_irq(8'h20, 8'h00);
    expect_irq(5);
    wr_st(2'd0, 16'h3333);
    wr_st(2'd2, 16'h007F);
    force_irq(8'h04, 8'h00);
    expect_irq(2);
    wr_st(2'd0, 16'h5555);
    do_rti();
    #1;
    check(astat == 16'h3333 && mstat == 16'h2222 && imask == 8'h7F, "R8", "first restore", astat, 16'h3333);
    do_rti();
    #1;
    check(astat == 16'h1111 && imask == 8'hFF, "R8", "second restore", astat, 16'h1111);

    // R9: underflow
    do_rti();
    #1;
    check(stk_unf && astat == 16'h1111 && stk_depth == 0, "R9", "empty pop", astat, 16'h1111);

    // R11: valid dropped during rti
    force_irq(8'h10, 8'h00);
    expect_irq(4);
    force_irq(8'h02, 8'h00);
    #1;
    check(irq_valid && irq_vector == vec_of(1), "R11", "offer before rti", irq_vector, vec_of(1));
    @(negedge clk) rti = 1'b1;
    #1;
    check(irq_valid == 1'b0, "R11", "valid in rti cycle", irq_valid, 0);
    @(negedge clk) rti = 1'b0;
    #1;
    check(irq_valid == 1'b1, "R11", "offer after rti", irq_valid, 1);
    expect_irq(1);
    do_rti();

    // R10: overflow by eight nested levels
    for (int i = 7; i >= 0; i--) begin
      force_irq(8'(1 << i), 8'h00);
      expect_irq(i);
      if (i == 1) begin
        #1;
        check(stk_depth == 3'd7 && !stk_ovf, "R10", "full stack", stk_depth, 7);
      end
    end
    #1;
    check(stk_ovf && stk_depth == 3'd7, "R10", "overflow", stk_depth, 7);
    for (int k = 0; k < 8; k++) do_rti();
    #1;
    check(stk_depth == 0 && stk_ovf, "R10", "ovf sticky", stk_ovf, 1);

    idle(2);
    check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule